// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block is a hardware master for a three-wire serial EEPROM that stores 16-bit words. A host asks for one word at a time over a request/acknowledge port. It supplies a read-or-write flag, a word address and, for writes, the data. The block then produces every chip-select, clock and data-in transition that the access needs. It samples the device's data-out line to gather read data and to learn when a program cycle has finished. The serial clock comes from a free-running divider on the system clock. The divider is held in reset while the block is idle, so every access starts with the same phase.

A read is a single selected frame: the read command, then sixteen clocks that gather the word. A write is a fixed chain. It begins with a write-enable frame, then the write command and sixteen data bits. Chip select is then dropped and raised, and data-out is polled at a fixed spacing until the device reports ready or a poll budget runs out. A write-disable frame always closes the chain. If the budget runs out, a sticky error flag is set. That flag clears when the next request is accepted.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, chip select, serial clock, serial data-in, busy, done and timeout_err are all low.
- R2: A read returns, on rd_data when done pulses, the 16 bits the device drove on data-out during the sixteen clocks that follow the read command. The first bit becomes bit 15.
- R3: Every command is an 11-bit frame sent most significant bit first. Bit 10 is a start bit of 1. Bits 9:8 are the opcode: 10 for read, 01 for write, 00 for control. Bits 7:0 are the word address. Write-enable is 0x4C0, write-disable is 0x400, read is 0x600 plus the address, and write is 0x500 plus the address.
- R4: Chip select is low for at least one tick before each command frame. A read causes exactly one rising edge of chip select. A write causes exactly four: enable, write, the re-select for polling, and disable.
- R5: Serial data-in changes only while the serial clock is low. A write's 16 data bits follow its write command in the same selection, most significant bit first.
- R6: After the last data bit of a write, chip select drops for one tick and then rises again. Data-out is sampled every POLL_GAP ticks. Write-disable is sent only after a sample reads high.
- R7: If POLL_LIMIT samples in a row read low, timeout_err is set, write-disable is still sent and done still pulses. timeout_err stays set until the next request is accepted, and it is low in the cycle after that acceptance.
- R8: A request is accepted in any cycle where busy is low and req is high, and this includes the cycle in which done pulses. busy is high from the following cycle until the done cycle. done is a single-cycle pulse.
- R9: The serial clock is high only while chip select is high. In the done cycle, chip select, serial clock and data-in are all low.
- R10: Each high phase of the serial clock lasts exactly CLK_DIV system cycles, and the serial clock changes only on a divider tick.
- R11: A request raised while busy is high has no effect on the current access and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled while busy is low |
| req_write | input | 1 | 1 = write word, 0 = read word |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to program |
| rd_data | output | DATA_W | Word returned by the last read |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| timeout_err | output | 1 | Sticky ready-poll timeout flag |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
The end of one access and the acceptance of the next can fall in the same cycle: done pulses while busy is already low, so a request held high through that cycle must be taken there. The bench provokes this by leaving req high across the done pulse of a timed-out write, with the read parameters for the next access already on the port. It then checks three things: busy was low for exactly that one cycle, timeout_err was set at done and cleared one cycle later, and the following read returns the right word.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_DESEL, S_SEL, S_SHIFT, S_DROP, S_RAISE, S_POLL, S_FINISH
    } step_e;

    typedef enum logic [2:0] {
        F_WEN, F_WRCMD, F_WRDATA, F_RDCMD, F_RDDATA, F_WDS
    } frame_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_CTRL  = 2'b00;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
    parameter int CLK_DIV = 132
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(CLK_DIV + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)                    cnt <= '0;
        else if (cnt == CW'(CLK_DIV - 1))   cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CW'(CLK_DIV - 1));
endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
    parameter int POLL_GAP   = 3,
    parameter int POLL_LIMIT = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    output logic sample,
    output logic last
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] poll_cnt;

    assign sample = active && tick && (gap_cnt == GW'(POLL_GAP - 1));
    assign last   = (poll_cnt == PW'(POLL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            gap_cnt  <= '0;
            poll_cnt <= '0;
        end else if (tick) begin
            if (gap_cnt == GW'(POLL_GAP - 1)) begin
                gap_cnt <= '0;
                if (!last) poll_cnt <= poll_cnt + 1'b1;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= PW'(POLL_LIMIT - 1));
endmodule

// File: rtl/mw_seq.sv
module mw_seq
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ee_do,
    input  logic              poll_sample,
    input  logic              poll_last,
    output step_e             step,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);
    localparam int CMD_W = 3 + ADDR_W;
    localparam int SH_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int NW    = $clog2(SH_W + 1);

    frame_e            frame;
    logic [SH_W-1:0]   shreg;
    logic [NW-1:0]     bits_left;
    logic              hi;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;

    function automatic logic [CMD_W-1:0] mk_cmd(frame_e f, logic [ADDR_W-1:0] a);
        case (f)
            F_WEN:   mk_cmd = {1'b1, OP_CTRL, 2'b11, {(ADDR_W-2){1'b0}}};
            F_WRCMD: mk_cmd = {1'b1, OP_WRITE, a};
            F_RDCMD: mk_cmd = {1'b1, OP_READ, a};
            default: mk_cmd = {1'b1, OP_CTRL, {ADDR_W{1'b0}}};
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            step        <= S_IDLE;
            frame       <= F_RDCMD;
            shreg       <= '0;
            bits_left   <= '0;
            hi          <= 1'b0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            rd_data     <= '0;
            op_addr     <= '0;
            op_wdata    <= '0;
        end else begin
            done <= 1'b0;
            if (step == S_IDLE) begin
                if (req) begin
                    op_addr     <= req_addr;
                    op_wdata    <= req_wdata;
                    timeout_err <= 1'b0;
                    frame       <= req_write ? F_WEN : F_RDCMD;
                    step        <= S_DESEL;
                end
            end else if (tick) begin
                case (step)
                    S_DESEL: step <= S_SEL;
                    S_SEL: begin
                        shreg     <= SH_W'(mk_cmd(frame, op_addr)) << (SH_W - CMD_W);
                        bits_left <= NW'(CMD_W);
                        hi        <= 1'b0;
                        step      <= S_SHIFT;
                    end
                    S_SHIFT: begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi        <= 1'b0;
                            shreg     <= {shreg[SH_W-2:0], ee_do};
                            bits_left <= bits_left - 1'b1;
                            if (bits_left == NW'(1)) begin
                                case (frame)
                                    F_WEN: begin
                                        frame <= F_WRCMD;
                                        step  <= S_DESEL;
                                    end
                                    F_WRCMD: begin
                                        frame     <= F_WRDATA;
                                        shreg     <= SH_W'(op_wdata) << (SH_W - DATA_W);
                                        bits_left <= NW'(DATA_W);
                                    end
                                    F_RDCMD: begin
                                        frame     <= F_RDDATA;
                                        shreg     <= '0;
                                        bits_left <= NW'(DATA_W);
                                    end
                                    F_RDDATA: begin
                                        rd_data <= {shreg[DATA_W-2:0], ee_do};
                                        step    <= S_FINISH;
                                    end
                                    F_WRDATA: step <= S_DROP;
                                    default:  step <= S_FINISH;
                                endcase
                            end
                        end
                    end
                    S_DROP:  step <= S_RAISE;
                    S_RAISE: step <= S_POLL;
                    S_POLL: begin
                        if (poll_sample && (ee_do || poll_last)) begin
                            if (!ee_do) timeout_err <= 1'b1;
                            frame <= F_WDS;
                            step  <= S_DESEL;
                        end
                    end
                    default: begin
                        step <= S_IDLE;
                        done <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy  = (step != S_IDLE);
    assign ee_cs = (step == S_SEL) || (step == S_SHIFT) || (step == S_RAISE) || (step == S_POLL);
    assign ee_sk = (step == S_SHIFT) && hi;
    assign ee_di = (step == S_SHIFT) && (frame != F_RDDATA) && shreg[SH_W-1];

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst) (!busy && req) |=> busy);
    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (rst) (!busy && req) |=> !timeout_err);
    // R11
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> $stable(op_addr));
    // R5
    di_hold_chk: assert property (@(posedge clk) disable iff (rst) ee_sk |-> $stable(ee_di));
    // R4
    cs_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(ee_cs) |-> $past(!ee_sk && !ee_di));
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CLK_DIV    = 132,
    parameter int POLL_GAP   = 3,
    parameter int POLL_LIMIT = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic  tick, poll_sample, poll_last;
    step_e step;

    mw_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .tick(tick)
    );

    mw_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .active(step == S_POLL), .tick(tick),
        .sample(poll_sample), .last(poll_last)
    );

    mw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ee_do(ee_do),
        .poll_sample(poll_sample), .poll_last(poll_last), .step(step),
        .rd_data(rd_data), .busy(busy), .done(done), .timeout_err(timeout_err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
    );

    // R10
    sk_on_tick_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(ee_sk));
    // R9
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst) ee_sk |-> ee_cs);
endmodule

// File: tb/mw_eeprom_ctrl_tb.sv
`timescale 1ns/100ps
module mw_eeprom_ctrl_tb;
    localparam int DIV = 2, GAP = 2, LIM = 8, BUSY_CYC = 20;

    logic clk = 1'b0, rst = 1'b1;
    logic req = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic busy, done, timeout_err, ee_cs, ee_sk, ee_di, ee_do;

    always #2.5 clk = ~clk;

    mw_eeprom_ctrl #(.ADDR_W(8), .DATA_W(16), .CLK_DIV(DIV), .POLL_GAP(GAP), .POLL_LIMIT(LIM)) u_dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .busy(busy), .done(done),
        .timeout_err(timeout_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0, failures = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 16'h0101) ^ 16'h5A3C;
    endfunction
    function automatic logic [15:0] wr_word(input int a);
        return 16'(a * 16'h03B1) ^ 16'hC35A;
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [0:255];
    logic [10:0] flog [0:7];
    int nlog = 0, cs_rises = 0, wds_early = 0, ready_at = 0;
    int mode = 0, bitn = 0, rdi = 0, wbits = 0;
    logic [10:0] sr = '0;
    logic [15:0] wsr = '0, rdw = '0;
    logic [7:0]  wa = '0;
    logic wen = 1'b0, rd_bit = 1'b0, stuck = 1'b0;

    initial for (int a = 0; a < 256; a++) mem[a] = init_word(a);

    always @(posedge clk) cyc <= cyc + 1;

    always_comb ee_do = (mode == 1) ? rd_bit : (!stuck && (cyc >= ready_at));

    always @(posedge ee_cs or posedge ee_sk) begin
        if (!ee_sk) begin
            cs_rises++; mode = 0; bitn = 0; sr = '0;
        end else if (ee_cs) begin
            case (mode)
                0: begin
                    sr = {sr[9:0], ee_di};
                    bitn++;
                    if (bitn == 11) begin
                        flog[nlog % 8] = sr;
                        nlog++;
                        mode = 3;
                        if (sr[9:8] == 2'b10) begin
                            mode = 1; rdw = mem[sr[7:0]]; rdi = 0;
                        end else if (sr[9:8] == 2'b01) begin
                            mode = 2; wa = sr[7:0]; wbits = 0;
                        end else if (sr[7:6] == 2'b11) begin
                            wen = 1'b1;
                        end else if (sr[7:6] == 2'b00) begin
                            wen = 1'b0;
                            if (stuck || cyc < ready_at) wds_early++;
                        end
                    end
                end
                1: begin rd_bit = rdw[15 - rdi]; rdi++; end
                2: begin
                    wsr = {wsr[14:0], ee_di};
                    wbits++;
                    if (wbits == 16) begin
                        if (wen) mem[wa] = wsr;
                        ready_at = cyc + BUSY_CYC;
                        mode = 3;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- monitors ----------------
    int hi_run = 0, bad_width = 0, widths = 0, sk_no_cs = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (ee_sk && !ee_cs) sk_no_cs++;
            if (ee_sk) hi_run++;
            else if (hi_run > 0) begin
                widths++;
                if (hi_run != DIV) bad_width++;
                hi_run = 0;
            end
        end
    end

    // ---------------- host tasks ----------------
    int done_cyc = 0;
    task automatic start_op(input bit wr, input int a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = 8'(a); req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask
    task automatic wait_done();
        while (!done) @(negedge clk);
        done_cyc = cyc;
    endtask
    task automatic run_op(input bit wr, input int a, input logic [15:0] d);
        start_op(wr, a, d);
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        wait_done();
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R9 lines low at done", {ee_cs, ee_sk, ee_di}, 0);
    endtask

    initial begin
        int n0, c0, wd0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R1 in reset",
            {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R1 after reset",
            {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);

        // R2 R3 R4 read sweep over every address
        for (int a = 0; a < 256; a++) begin
            n0 = nlog; c0 = cs_rises;
            run_op(1'b0, a, 16'h0);
            chk(rd_data == init_word(a), "R2 read word", rd_data, init_word(a));
            chk(nlog == n0 + 1 && flog[n0 % 8] == 11'(12'h600 + a), "R3 read frame", flog[n0 % 8], 12'h600 + a);
            chk(cs_rises == c0 + 1, "R4 read selects", cs_rises - c0, 1);
        end

        // R3 R4 R5 R6 write sweep
        for (int a = 0; a < 256; a += 8) begin
            n0 = nlog; c0 = cs_rises; wd0 = wds_early;
            run_op(1'b1, a, wr_word(a));
            chk(nlog == n0 + 3, "R3 write frame count", nlog - n0, 3);
            chk(flog[n0 % 8] == 11'h4C0, "R3 enable frame", flog[n0 % 8], 11'h4C0);
            chk(flog[(n0 + 1) % 8] == 11'(12'h500 + a), "R3 write frame", flog[(n0 + 1) % 8], 12'h500 + a);
            chk(flog[(n0 + 2) % 8] == 11'h400, "R3 disable frame", flog[(n0 + 2) % 8], 11'h400);
            chk(cs_rises == c0 + 4, "R4 write selects", cs_rises - c0, 4);
            chk(wds_early == wd0, "R6 disable after ready", wds_early - wd0, 0);
            chk(done_cyc >= ready_at, "R6 done after ready", done_cyc, ready_at);
            chk(timeout_err == 1'b0, "R7 no timeout", timeout_err, 0);
        end
        for (int a = 0; a < 256; a += 8) begin
            run_op(1'b0, a, 16'h0);
            chk(rd_data == wr_word(a), "R5 readback of written word", rd_data, wr_word(a));
        end

        // R11 request while busy is ignored
        n0 = nlog;
        start_op(1'b0, 20, 16'h0);
        repeat (10) @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 8'd30; req_wdata = 16'hDEAD;
        @(negedge clk);
        req = 1'b0;
        wait_done();
        chk(rd_data == init_word(20), "R11 current read intact", rd_data, init_word(20));
        repeat (5) @(negedge clk);
        chk(nlog == n0 + 1 && !busy, "R11 no extra access", nlog - n0, 1);
        run_op(1'b0, 30, 16'h0);
        chk(rd_data == init_word(30), "R11 target word untouched", rd_data, init_word(30));

        // R7 timeout with a device that never becomes ready
        stuck = 1'b1;
        n0 = nlog;
        run_op(1'b1, 5, 16'h1234);
        chk(timeout_err == 1'b1, "R7 timeout flag", timeout_err, 1);
        chk(flog[(n0 + 2) % 8] == 11'h400, "R7 disable after timeout", flog[(n0 + 2) % 8], 11'h400);
        repeat (20) @(negedge clk);
        chk(timeout_err == 1'b1, "R7 flag sticky", timeout_err, 1);

        // R8 R7 request held across done: accepted in the done cycle
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 8'd6; req_wdata = 16'h4321;
        wait_done();
        chk(busy == 1'b0 && timeout_err == 1'b1, "R8 done cycle idle with error", {busy, timeout_err}, 1);
        req_write = 1'b0; req_addr = 8'd9;
        @(negedge clk);
        req = 1'b0;
        chk(busy == 1'b1, "R8 accepted in done cycle", busy, 1);
        chk(timeout_err == 1'b0, "R7 cleared on accept", timeout_err, 0);
        wait_done();
        chk(rd_data == init_word(9), "R2 back-to-back read", rd_data, init_word(9));
        stuck = 1'b0;

        // R9 R10 serial clock shape over the whole run
        chk(sk_no_cs == 0, "R9 clock without select", sk_no_cs, 0);
        chk(widths > 0 && bad_width == 0, "R10 clock high width", bad_width, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule